// File: doc/BRIEF.md
# Indexed BCD Real-Time Clock

This block is a calendar clock that keeps the time of day and the date as sixteen nibble-wide registers: thirteen decimal digit registers (seconds, minutes, hours, day of month, month, year, each split into a units and a tens digit, plus a weekday counter) and three control registers. Time advances by one second on each pulse of a one-pulse-per-second tick input, with decimal carries, month lengths and a leap-year February.

A host reaches all registers through three byte-wide locations: an enable register, one shared command/index/data port and a ready-status register. After the port is enabled, the host sends a command byte, then a register index, and from then on every data read or data write moves to the next register. The host reads a shadow copy of the time. The shadow can be frozen while the live counters keep running, so that a multi-byte read sees one consistent time. Control bits stop the clock, hold it with the seconds cleared, choose 12- or 24-hour format and enable a once-per-second interrupt pulse.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the enable register reads 00 and the status reads 80. Registers 0 to C read zero, except register 6 (day units) and register 8 (month units), which read 01. Control registers D, E and F read 01, 0F and 06.
- R2: Host address 0 is the enable register (bit 0 enables the port), address 1 is the port and address 2 is the status. While bit 0 is clear, port writes change nothing and port reads return 00.
- R3: Writing the enable register restarts the port sequence. The first port write after that is a command byte: 03 or 0C moves on to the index step, and any other value is ignored, so the port keeps waiting for a command.
- R4: The write after the command sets the register index (low four bits). From then on each port data read or data write advances the index by one, and index F wraps to 0. Port reads return 00 before the index has been set.
- R5: Status bit 7 is the ready flag. Any port access clears it, and it is set again one clock later. A status read that returns it as 1 clears it.
- R6: In 24-hour mode a tick advances seconds 0-59, minutes 0-59 and hours 0-23 with decimal carries. The day rolls from the month's length to 1. February has 29 days when the two-digit year is divisible by 4 and 28 otherwise. Month runs 1-12 and year 00-99. The weekday (register C) counts 0-6 on each day carry.
- R7: When bit 2 of register F is 0, hours run 12, 1, ..., 11, and bit 2 of register 5 (hours tens) is the PM flag (1 = PM). Going from 11 to 12 toggles the flag. The day advances only on the step from 11 PM to 12 AM.
- R8: While bit 0 of register D is 1, host-visible time registers hold their values but the live time keeps counting. The shadow is refreshed at the next tick after the bit is cleared.
- R9: While bit 1 of register F is 1, ticks do not advance the time.
- R10: While bit 0 of register F is 1, the seconds digits are held at 00 and ticks do not advance the time.
- R11: When bit 1 of register D is 1, irq_o is high for exactly one clock, the clock after each tick. Otherwise irq_o stays low.
- R12: A data write to registers 0 to C takes effect in the live counters at once and becomes visible to host reads unless frozen. Later ticks count on from the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| host_wr_i | input | 1 | Host write strobe, one cycle per access |
| host_rd_i | input | 1 | Host read strobe, one cycle per access |
| host_addr_i | input | 2 | 0 enable, 1 port, 2 status |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Read data, valid in the cycle the read strobe is high, 00 otherwise |
| sec_tick_i | input | 1 | One-cycle pulse per second |
| irq_o | output | 1 | One-cycle interrupt pulse per tick when enabled |

## Verification
The bench targets the rollover chain from 23:59:59 on 31 December of year 99. It also covers February 28 and 29 in leap and non-leap years, 30-day months, and the 12-hour steps 11 to 12 and 12 to 1, where a design that carried the day at 12 noon or never set the PM flag would show the wrong date or hour. It checks that a non-command byte is truly ignored, since a port that took it as the command would write the next byte into a time digit. The freeze test reads the same time after several ticks and then, after one more tick, sees all of them, which a design that stopped the counters instead of the shadow would fail. The bench also covers index wrap from F to 0, the ready flag's 0-1-0 pattern after an access, and the held seconds under the clear bit.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;

    localparam int NUM_TIME   = 13;
    localparam int NIB_W      = 4;
    localparam int BYTE_W     = 8;
    localparam int IDX_W      = 4;
    localparam int ADDR_W     = 2;
    localparam int BIN_W      = 8;

    localparam logic [ADDR_W-1:0] A_ENABLE = 2'd0;
    localparam logic [ADDR_W-1:0] A_PORT   = 2'd1;
    localparam logic [ADDR_W-1:0] A_STATUS = 2'd2;

    localparam logic [BYTE_W-1:0] CMD_SEQ_A = 8'h03;
    localparam logic [BYTE_W-1:0] CMD_SEQ_B = 8'h0C;

    localparam int I_SEC1  = 0;
    localparam int I_SEC10 = 1;
    localparam int I_MIN1  = 2;
    localparam int I_MIN10 = 3;
    localparam int I_HR1   = 4;
    localparam int I_HR10  = 5;
    localparam int I_DAY1  = 6;
    localparam int I_DAY10 = 7;
    localparam int I_MON1  = 8;
    localparam int I_MON10 = 9;
    localparam int I_YR1   = 10;
    localparam int I_YR10  = 11;
    localparam int I_WDAY  = 12;

    localparam logic [IDX_W-1:0] I_CTL_D = 4'hD;
    localparam logic [IDX_W-1:0] I_CTL_E = 4'hE;
    localparam logic [IDX_W-1:0] I_CTL_F = 4'hF;

    localparam int BIT_FREEZE = 0;
    localparam int BIT_IRQ_EN = 1;
    localparam int BIT_HOLD0  = 0;
    localparam int BIT_STOP   = 1;
    localparam int BIT_H24    = 2;

    typedef enum logic [1:0] {PH_CMD, PH_IDX, PH_DATA} phase_e;

    typedef logic [NUM_TIME-1:0][NIB_W-1:0] time_t;

    typedef struct packed {
        logic              en;
        phase_e            phase;
        logic [IDX_W-1:0]  idx;
        logic              ready;
        logic              pend;
        logic              irq;
        time_t             live;
        time_t             shadow;
        logic [NIB_W-1:0]  ctl_d;
        logic [NIB_W-1:0]  ctl_e;
        logic [NIB_W-1:0]  ctl_f;
    } state_t;

    function automatic time_t time_reset();
        time_t t;
        t = '0;
        t[I_DAY1] = 4'd1;
        t[I_MON1] = 4'd1;
        return t;
    endfunction

    function automatic state_t state_reset();
        state_t s;
        s        = '0;
        s.phase  = PH_CMD;
        s.ready  = 1'b1;
        s.live   = time_reset();
        s.shadow = time_reset();
        s.ctl_d  = 4'h1;
        s.ctl_e  = 4'hF;
        s.ctl_f  = 4'h6;
        return s;
    endfunction

    function automatic logic [BIN_W-1:0] bcd2bin(input logic [NIB_W-1:0] tens,
                                                 input logic [NIB_W-1:0] units);
        return ({4'd0, tens} * 8'd10) + {4'd0, units};
    endfunction

    function automatic logic [BIN_W-1:0] bin2bcd(input logic [BIN_W-1:0] v);
        return ((v / 8'd10) << 4) | (v % 8'd10);
    endfunction

    // {carry, value}: step v by one when cin, wrapping from hi (or above) to lo
    function automatic logic [BIN_W:0] wrap_inc(input logic [BIN_W-1:0] v,
                                                input logic             cin,
                                                input logic [BIN_W-1:0] lo,
                                                input logic [BIN_W-1:0] hi);
        if (!cin)    return {1'b0, v};
        if (v >= hi) return {1'b1, lo};
        return {1'b0, v + 8'd1};
    endfunction

    function automatic logic [BIN_W-1:0] month_days(input logic [BIN_W-1:0] mon,
                                                    input logic             leap);
        case (mon)
            8'd2:                     return leap ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11:  return 8'd30;
            default:                  return 8'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_hour_step.sv
`timescale 1ns/1ps
module rtc_hour_step
    import rtc_pkg::*;
(
    input  logic [NIB_W-1:0] units_i,
    input  logic [NIB_W-1:0] tens_i,
    input  logic             mode24_i,
    input  logic             cin_i,
    output logic [NIB_W-1:0] units_o,
    output logic [NIB_W-1:0] tens_o,
    output logic             cout_o
);

    logic [BIN_W:0]   h24_r;
    logic [BIN_W-1:0] h12;
    logic [BIN_W-1:0] h12_n;
    logic             pm_n;
    logic [BIN_W-1:0] b;

    always_comb begin
        units_o = units_i;
        tens_o  = tens_i;
        cout_o  = 1'b0;
        h24_r   = wrap_inc(bcd2bin(tens_i, units_i), cin_i, 8'd0, 8'd23);
        h12     = bcd2bin({2'b00, tens_i[1:0]}, units_i);
        h12_n   = h12;
        pm_n    = tens_i[2];
        b       = '0;
        if (cin_i) begin
            if (mode24_i) begin
                b       = bin2bcd(h24_r[BIN_W-1:0]);
                units_o = b[3:0];
                tens_o  = b[7:4];
                cout_o  = h24_r[BIN_W];
            end else begin
                if (h12 == 8'd11) begin
                    h12_n  = 8'd12;
                    pm_n   = ~tens_i[2];
                    cout_o = tens_i[2];
                end else if (h12 >= 8'd12) begin
                    h12_n = 8'd1;
                end else begin
                    h12_n = h12 + 8'd1;
                end
                b       = bin2bcd(h12_n);
                units_o = b[3:0];
                tens_o  = {1'b0, pm_n, b[5:4]};
            end
        end
    end

endmodule

// File: rtl/rtc_calendar_step.sv
`timescale 1ns/1ps
module rtc_calendar_step
    import rtc_pkg::*;
(
    input  time_t cur_i,
    input  logic  mode24_i,
    output time_t nxt_o
);

    logic [BIN_W:0]   sec_r, min_r, day_r, mon_r, yr_r, wd_r;
    logic [BIN_W-1:0] sec_b, min_b, day_b, mon_b, yr_b;
    logic [BIN_W-1:0] mon_bin, yr_bin;
    logic             leap;
    logic [NIB_W-1:0] hr_units, hr_tens;
    logic             hr_carry;
    logic             unused_bits;

    assign mon_bin = bcd2bin(cur_i[I_MON10], cur_i[I_MON1]);
    assign yr_bin  = bcd2bin(cur_i[I_YR10], cur_i[I_YR1]);
    assign leap    = (yr_bin[1:0] == 2'b00);

    always_comb begin
        sec_r = wrap_inc(bcd2bin(cur_i[I_SEC10], cur_i[I_SEC1]), 1'b1, 8'd0, 8'd59);
        min_r = wrap_inc(bcd2bin(cur_i[I_MIN10], cur_i[I_MIN1]), sec_r[BIN_W], 8'd0, 8'd59);
    end

    rtc_hour_step u_hour (
        .units_i  (cur_i[I_HR1]),
        .tens_i   (cur_i[I_HR10]),
        .mode24_i (mode24_i),
        .cin_i    (min_r[BIN_W]),
        .units_o  (hr_units),
        .tens_o   (hr_tens),
        .cout_o   (hr_carry)
    );

    always_comb begin
        day_r = wrap_inc(bcd2bin(cur_i[I_DAY10], cur_i[I_DAY1]), hr_carry, 8'd1,
                         month_days(mon_bin, leap));
        mon_r = wrap_inc(mon_bin, day_r[BIN_W], 8'd1, 8'd12);
        yr_r  = wrap_inc(yr_bin, mon_r[BIN_W], 8'd0, 8'd99);
        wd_r  = wrap_inc({4'd0, cur_i[I_WDAY]}, hr_carry, 8'd0, 8'd6);

        sec_b = bin2bcd(sec_r[BIN_W-1:0]);
        min_b = bin2bcd(min_r[BIN_W-1:0]);
        day_b = bin2bcd(day_r[BIN_W-1:0]);
        mon_b = bin2bcd(mon_r[BIN_W-1:0]);
        yr_b  = bin2bcd(yr_r[BIN_W-1:0]);

        nxt_o          = cur_i;
        nxt_o[I_SEC1]  = sec_b[3:0];
        nxt_o[I_SEC10] = sec_b[7:4];
        nxt_o[I_MIN1]  = min_b[3:0];
        nxt_o[I_MIN10] = min_b[7:4];
        nxt_o[I_HR1]   = hr_units;
        nxt_o[I_HR10]  = hr_tens;
        nxt_o[I_DAY1]  = day_b[3:0];
        nxt_o[I_DAY10] = day_b[7:4];
        nxt_o[I_MON1]  = mon_b[3:0];
        nxt_o[I_MON10] = mon_b[7:4];
        nxt_o[I_YR1]   = yr_b[3:0];
        nxt_o[I_YR10]  = yr_b[7:4];
        nxt_o[I_WDAY]  = wd_r[3:0];
    end

    assign unused_bits = ^{yr_r[BIN_W], wd_r[BIN_W:4]};

endmodule

// File: rtl/bcd_rtc_core.sv
`timescale 1ns/1ps
module bcd_rtc_core
    import rtc_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              host_wr_i,
    input  logic              host_rd_i,
    input  logic [ADDR_W-1:0] host_addr_i,
    input  logic [BYTE_W-1:0] host_wdata_i,
    output logic [BYTE_W-1:0] host_rdata_o,
    input  logic              sec_tick_i,
    output logic              irq_o
);

    state_t st_q, st_d;
    time_t  step_nxt;

    logic port_sel, port_wr, data_wr, data_rd, port_acc, stat_rd, advance;
    logic [BYTE_W-1:0] reg_rd, rd_val;

    rtc_calendar_step u_step (
        .cur_i    (st_q.live),
        .mode24_i (st_q.ctl_f[BIT_H24]),
        .nxt_o    (step_nxt)
    );

    assign port_sel = (host_addr_i == A_PORT) && st_q.en;
    assign port_wr  = host_wr_i && port_sel;
    assign data_wr  = port_wr && (st_q.phase == PH_DATA);
    assign data_rd  = host_rd_i && !host_wr_i && port_sel && (st_q.phase == PH_DATA);
    assign port_acc = port_wr || data_rd;
    assign stat_rd  = host_rd_i && !host_wr_i && (host_addr_i == A_STATUS);
    assign advance  = sec_tick_i && !st_q.ctl_f[BIT_HOLD0] && !st_q.ctl_f[BIT_STOP];

    always_comb begin
        st_d      = st_q;
        st_d.pend = 1'b0;
        st_d.irq  = sec_tick_i && st_q.ctl_d[BIT_IRQ_EN];

        // ready: status read clears, pending access sets, new access clears
        if (stat_rd)    st_d.ready = 1'b0;
        if (st_q.pend)  st_d.ready = 1'b1;
        if (port_acc) begin
            st_d.ready = 1'b0;
            st_d.pend  = 1'b1;
        end

        if (host_wr_i && (host_addr_i == A_ENABLE)) begin
            st_d.en    = host_wdata_i[0];
            st_d.phase = PH_CMD;
        end

        if (port_wr) begin
            unique case (st_q.phase)
                PH_CMD: begin
                    if ((host_wdata_i == CMD_SEQ_A) || (host_wdata_i == CMD_SEQ_B))
                        st_d.phase = PH_IDX;
                end
                PH_IDX: begin
                    st_d.idx   = host_wdata_i[IDX_W-1:0];
                    st_d.phase = PH_DATA;
                end
                PH_DATA: st_d.phase = PH_DATA;
                default: st_d.phase = PH_CMD;
            endcase
        end

        st_d.live = advance ? step_nxt : st_q.live;

        if (data_wr) begin
            if (st_q.idx < IDX_W'(NUM_TIME)) begin
                st_d.live[st_q.idx] = host_wdata_i[NIB_W-1:0];
            end else begin
                case (st_q.idx)
                    I_CTL_D: st_d.ctl_d = host_wdata_i[NIB_W-1:0];
                    I_CTL_E: st_d.ctl_e = host_wdata_i[NIB_W-1:0];
                    default: st_d.ctl_f = host_wdata_i[NIB_W-1:0];
                endcase
            end
        end

        if (data_wr || data_rd) st_d.idx = st_q.idx + 1'b1;

        if (st_d.ctl_f[BIT_HOLD0]) begin
            st_d.live[I_SEC1]  = '0;
            st_d.live[I_SEC10] = '0;
        end

        if (!st_q.ctl_d[BIT_FREEZE] && (sec_tick_i || data_wr))
            st_d.shadow = st_d.live;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= state_reset();
        else         st_q <= st_d;
    end

    always_comb begin
        if (st_q.idx < IDX_W'(NUM_TIME)) begin
            reg_rd = {4'd0, st_q.shadow[st_q.idx]};
        end else begin
            case (st_q.idx)
                I_CTL_D: reg_rd = {4'd0, st_q.ctl_d};
                I_CTL_E: reg_rd = {4'd0, st_q.ctl_e};
                default: reg_rd = {4'd0, st_q.ctl_f};
            endcase
        end
        case (host_addr_i)
            A_ENABLE: rd_val = {7'd0, st_q.en};
            A_PORT:   rd_val = (st_q.en && (st_q.phase == PH_DATA)) ? reg_rd : '0;
            A_STATUS: rd_val = {st_q.ready, 7'd0};
            default:  rd_val = '0;
        endcase
    end

    assign host_rdata_o = host_rd_i ? rd_val : '0;
    assign irq_o        = st_q.irq;

endmodule

// File: rtl/rtc_checker.sv
`timescale 1ns/1ps
module rtc_checker
    import rtc_pkg::*;
(
    input logic             clk_i,
    input logic             rst_ni,
    input logic             port_acc,
    input logic             data_acc,
    input logic             data_wr,
    input logic             sec_tick_i,
    input logic             irq_o,
    input logic             ready,
    input logic [IDX_W-1:0] idx,
    input logic [NIB_W-1:0] ctl_d,
    input logic [NIB_W-1:0] ctl_f,
    input time_t            live,
    input time_t            shadow
);

    // R5
    a_r5_busy_after_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
        port_acc |=> !ready);

    // R5
    a_r5_ready_returns: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!port_acc && $past(port_acc)) |=> ready);

    // R4
    a_r4_index_advances: assert property (@(posedge clk_i) disable iff (!rst_ni)
        data_acc |=> (idx == $past(idx) + 4'd1));

    // R11
    a_r11_irq_follows_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sec_tick_i && ctl_d[BIT_IRQ_EN]) |=> irq_o);

    // R11
    a_r11_irq_only_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sec_tick_i |=> !irq_o);

    // R8
    a_r8_frozen_shadow: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctl_d[BIT_FREEZE] |=> $stable(shadow));

    // R9
    a_r9_stopped_time: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_f[BIT_STOP] && !data_wr) |=> $stable(live));

    // R10
    a_r10_seconds_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ctl_f[BIT_HOLD0] |-> ((live[I_SEC1] == 4'd0) && (live[I_SEC10] == 4'd0)));

endmodule

bind bcd_rtc_core rtc_checker chk_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .port_acc   (port_acc),
    .data_acc   (data_wr || data_rd),
    .data_wr    (data_wr),
    .sec_tick_i (sec_tick_i),
    .irq_o      (irq_o),
    .ready      (st_q.ready),
    .idx        (st_q.idx),
    .ctl_d      (st_q.ctl_d),
    .ctl_f      (st_q.ctl_f),
    .live       (st_q.live),
    .shadow     (st_q.shadow)
);

// File: tb/bcd_rtc_core_tb_top.sv
`timescale 1ns/1ps
module bcd_rtc_core_tb_top;

    localparam logic [1:0] A_EN = 2'd0, A_PORT = 2'd1, A_STAT = 2'd2;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       hwr = 1'b0, hrd = 1'b0, tick_in = 1'b0;
    logic [1:0] haddr = '0;
    logic [7:0] hwd = '0;
    logic [7:0] rdat;
    logic       irq;

    int nchk = 0, nfail = 0;
    int bs, bm, bh, bpm, bd, bmo, by, bw;
    bit h24;

    always #2.5 clk = ~clk;

    bcd_rtc_core dut_i (
        .clk_i(clk), .rst_ni(rst_n), .host_wr_i(hwr), .host_rd_i(hrd),
        .host_addr_i(haddr), .host_wdata_i(hwd), .host_rdata_o(rdat),
        .sec_tick_i(tick_in), .irq_o(irq)
    );

    initial begin
        #750000;
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic int mlen(int mo, int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic model_tick();
        bs++;
        if (bs < 60) return;
        bs = 0; bm++;
        if (bm < 60) return;
        bm = 0;
        if (h24) begin
            bh++;
            if (bh < 24) return;
            bh = 0;
        end else begin
            if (bh == 11) begin
                bh = 12; bpm = 1 - bpm;
                if (bpm == 1) return;
            end else begin
                bh = (bh >= 12) ? 1 : bh + 1;
                return;
            end
        end
        bd++; bw = (bw + 1) % 7;
        if (bd <= mlen(bmo, by)) return;
        bd = 1; bmo++;
        if (bmo <= 12) return;
        bmo = 1; by = (by + 1) % 100;
    endtask

    function automatic logic [3:0] exp_nib(int i);
        case (i)
            0: return 4'(bs % 10);   1: return 4'(bs / 10);
            2: return 4'(bm % 10);   3: return 4'(bm / 10);
            4: return 4'(bh % 10);
            5: return h24 ? 4'(bh / 10) : 4'((bh / 10) + 4 * bpm);
            6: return 4'(bd % 10);   7: return 4'(bd / 10);
            8: return 4'(bmo % 10);  9: return 4'(bmo / 10);
            10: return 4'(by % 10);  11: return 4'(by / 10);
            default: return 4'(bw);
        endcase
    endfunction

    function automatic logic [63:0] exp_vec();
        logic [63:0] v = '0;
        for (int i = 0; i < 13; i++) v[i*4 +: 4] = exp_nib(i);
        return v;
    endfunction

    task automatic bus_wr(logic [1:0] a, logic [7:0] d);
        @(negedge clk); haddr = a; hwd = d; hwr = 1'b1;
        @(posedge clk); #1 hwr = 1'b0;
    endtask

    task automatic bus_rd(logic [1:0] a, output logic [7:0] d);
        @(negedge clk); haddr = a; hrd = 1'b1;
        #1 d = rdat;
        @(posedge clk); #1 hrd = 1'b0;
    endtask

    task automatic do_tick();
        @(negedge clk); tick_in = 1'b1;
        @(posedge clk); #1 tick_in = 1'b0;
    endtask

    task automatic goto_idx(int i, logic [7:0] cmd = 8'h03);
        bus_wr(A_EN, 8'h01);
        bus_wr(A_PORT, cmd);
        bus_wr(A_PORT, 8'(i));
    endtask

    task automatic read_time(output logic [63:0] v);
        logic [7:0] d;
        v = '0;
        goto_idx(0, 8'h0C);
        for (int i = 0; i < 13; i++) begin
            bus_rd(A_PORT, d);
            v[i*4 +: 4] = d[3:0];
        end
    endtask

    task automatic cmp_time(string req, string what);
        logic [63:0] v;
        read_time(v);
        check(req, what, v, exp_vec());
    endtask

    task automatic set_ctl(int d, int f);
        goto_idx(13);
        bus_wr(A_PORT, 8'(d));
        bus_wr(A_PORT, 8'h0F);
        bus_wr(A_PORT, 8'(f));
    endtask

    task automatic load_model();
        goto_idx(0);
        for (int i = 0; i < 13; i++) bus_wr(A_PORT, {4'd0, exp_nib(i)});
    endtask

    task automatic run(string req, string what, int s, int m, int h, int pm, int d,
                       int mo, int y, int w, bit m24, int n);
        h24 = m24; bs = s; bm = m; bh = h; bpm = pm; bd = d; bmo = mo; by = y; bw = w;
        set_ctl(0, m24 ? 4 : 0);
        load_model();
        repeat (n) begin do_tick(); model_tick(); end
        cmp_time(req, what);
    endtask

    initial begin
        logic [7:0]  d;
        logic [63:0] v, e, old;
        void'($urandom(32'd7731));

        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        bus_rd(A_STAT, d); check("R1", "status after reset", 64'(d), 64'h80);
        bus_rd(A_EN, d);   check("R1", "enable after reset", 64'(d), 64'h00);
        bus_rd(A_PORT, d); check("R2", "port read while disabled", 64'(d), 64'h00);
        goto_idx(0);
        v = '0;
        for (int i = 0; i < 16; i++) begin bus_rd(A_PORT, d); v[i*4 +: 4] = d[3:0]; end
        e = '0; e[6*4 +: 4] = 4'd1; e[8*4 +: 4] = 4'd1;
        e[52 +: 4] = 4'h1; e[56 +: 4] = 4'hF; e[60 +: 4] = 4'h6;
        check("R1", "register file after reset", v, e);

        // R6 directed 24-hour rollovers
        run("R6", "new year rollover", 59, 59, 23, 0, 31, 12, 99, 6, 1, 1);
        run("R6", "leap Feb 28 -> 29", 59, 59, 23, 0, 28, 2, 24, 2, 1, 1);
        run("R6", "leap Feb 29 -> Mar 1", 59, 59, 23, 0, 29, 2, 24, 3, 1, 1);
        run("R6", "plain Feb 28 -> Mar 1", 59, 59, 23, 0, 28, 2, 23, 1, 1, 1);
        run("R6", "Apr 30 -> May 1", 59, 59, 23, 0, 30, 4, 50, 4, 1, 2);
        run("R6", "minute carry", 58, 9, 7, 0, 15, 6, 10, 0, 1, 3);

        // R7 12-hour steps
        run("R7", "11 AM -> 12 PM", 59, 59, 11, 0, 10, 3, 5, 1, 0, 1);
        run("R7", "11 PM -> 12 AM next day", 59, 59, 11, 1, 31, 1, 5, 6, 0, 1);
        run("R7", "12 -> 1", 59, 59, 12, 1, 3, 3, 5, 2, 0, 1);

        // R12 write lands and counting continues
        run("R12", "loaded time readback", 10, 20, 15, 0, 9, 9, 42, 3, 1, 0);
        goto_idx(2); bus_wr(A_PORT, 8'h07); bm = (bm / 10) * 10 + 7;
        cmp_time("R12", "single digit write");
        do_tick(); model_tick();
        cmp_time("R12", "tick after write");

        // R4 index wrap F -> 0
        goto_idx(15);
        bus_rd(A_PORT, d); check("R4", "index F reads control F", 64'(d), 64'h04);
        bus_rd(A_PORT, d); check("R4", "wrap to index 0", 64'(d), 64'(exp_nib(0)));

        // R5 ready pattern after a data write (index now 1)
        bus_wr(A_PORT, {4'd0, exp_nib(1)});
        bus_rd(A_STAT, d); check("R5", "ready low right after access", 64'(d), 64'h00);
        bus_rd(A_STAT, d); check("R5", "ready back one clock later", 64'(d), 64'h80);
        bus_rd(A_STAT, d); check("R5", "ready cleared by status read", 64'(d), 64'h00);

        // R2 port ignored when disabled
        bus_wr(A_EN, 8'h00);
        bus_wr(A_PORT, 8'h03); bus_wr(A_PORT, 8'h00); bus_wr(A_PORT, 8'h09);
        bus_rd(A_PORT, d); check("R2", "disabled port read", 64'(d), 64'h00);
        cmp_time("R2", "time untouched by disabled writes");

        // R3 non-command byte ignored
        bus_wr(A_EN, 8'h01);
        bus_wr(A_PORT, 8'h55); bus_wr(A_PORT, 8'h03); bus_wr(A_PORT, 8'h0D);
        bus_rd(A_PORT, d); check("R3", "bad command ignored, index D read", 64'(d), 64'h00);
        cmp_time("R3", "time untouched after bad command");

        // R8 freeze
        run("R8", "freeze setup", 30, 20, 10, 0, 5, 5, 5, 5, 1, 0);
        old = exp_vec();
        goto_idx(13); bus_wr(A_PORT, 8'h01);
        repeat (3) begin do_tick(); model_tick(); end
        read_time(v); check("R8", "frozen view holds", v, old);
        goto_idx(13); bus_wr(A_PORT, 8'h00);
        read_time(v); check("R8", "view held until next tick", v, old);
        do_tick(); model_tick();
        cmp_time("R8", "live time kept counting");

        // R9 stop
        set_ctl(0, 6);
        repeat (3) do_tick();
        cmp_time("R9", "stopped clock ignores ticks");
        set_ctl(0, 4); do_tick(); model_tick();
        cmp_time("R9", "resumes after stop cleared");

        // R10 hold with seconds cleared
        goto_idx(0); bus_wr(A_PORT, 8'h07); bus_wr(A_PORT, 8'h03);
        set_ctl(0, 5); bs = 0;
        cmp_time("R10", "seconds cleared");
        do_tick();
        cmp_time("R10", "no advance while held");
        set_ctl(0, 4); do_tick(); model_tick();
        cmp_time("R10", "counts from 00 after release");

        // R11 interrupt pulse
        set_ctl(2, 4);
        @(negedge clk); tick_in = 1'b1;
        @(posedge clk); #1 tick_in = 1'b0; model_tick();
        check("R11", "irq after tick", 64'(irq), 64'd1);
        @(posedge clk); #1 check("R11", "irq one clock only", 64'(irq), 64'd0);
        set_ctl(0, 4);
        do_tick(); model_tick();
        check("R11", "no irq when disabled", 64'(irq), 64'd0);
        cmp_time("R11", "time after irq ticks");

        // Random R6/R7 near boundaries
        for (int it = 0; it < 40; it++) begin
            bit m24 = 1'($urandom % 2);
            int mo  = 1 + int'($urandom % 12);
            int y   = int'($urandom % 100);
            int dd  = ($urandom % 2) ? mlen(mo, y) : 1 + int'($urandom % mlen(mo, y));
            int hh  = m24 ? (($urandom % 2) ? 23 : int'($urandom % 24))
                          : (($urandom % 2) ? 11 : 1 + int'($urandom % 12));
            int ss  = ($urandom % 4 != 0) ? 59 : int'($urandom % 60);
            int mm  = ($urandom % 4 != 0) ? 59 : int'($urandom % 60);
            run(m24 ? "R6" : "R7", "random boundary", ss, mm, hh, int'($urandom % 2),
                dd, mo, y, int'($urandom % 7), m24, 1 + int'($urandom % 3));
        end

        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

endmodule